// File: doc/BRIEF.md
# Memory Protection Entry Register Bank

This block stores the programming state of a set of physical memory protection entries. Each entry has an 8-bit configuration byte and an address register. A machine security register sits beside them. Software reaches all of this through an indexed register port made of a write strobe, a space selector, an index, write data and combinational read data. Configuration bytes are packed into register-wide words, with one byte lane per entry.

Every write is filtered, per entry, by lock rules before it is stored. Those rules look at the entry's own lock bit, at whether the following entry is locked in top-of-range mode, and at sticky bits in the security register. A write that is refused leaves the state untouched and raises a single-cycle error strobe. The bank also drives the raw configuration, address and lock state of every entry, the security bits and a count of active entries to the address-match logic downstream.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset, every configuration byte, address register and security bit is zero, the active count is zero, the error strobe is low and reads of any space return zero.
- R2: Configuration word k carries entry BPW*k+i in byte lane i, where BPW is XLEN/8. Within a byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two) and bit 7 is the lock. Reads and `entry_cfg` return the stored bytes in the same lanes. Space code 0 selects configuration words.
- R3: Without enhanced rules in force (bypass and lockdown both clear), a byte aimed at a locked entry is dropped while the other lanes of the same word are still written.
- R4: While the bypass bit (security bit 2) is set, every configuration byte write is accepted, whether or not the entry is locked.
- R5: While lockdown (security bit 0) is set and bypass is clear, a configuration byte is accepted only if it has lock set and execute clear, or has lock clear and its bits 2:0 differ from 3'b110. Any other byte is dropped, even for an unlocked entry.
- R6: A write to address register n (space code 1) is dropped when entry n is locked. It is also dropped when entry n+1 exists, is locked and is in top-of-range mode. The last entry has no successor.
- R7: A write to a configuration word at or beyond the word count, to an address index at or beyond the entry count, or to space code 3 is dropped and flags an error. Reads of any of these return zero.
- R8: The security register (space code 2) keeps bit 0 (lockdown) and bit 1 (whitelist) set once they are set. Bit 2 (bypass) cannot change from 0 to 1 while any entry is locked. Writing the register never raises the error strobe.
- R9: `active_cnt` equals the number of entries whose match mode is not off, and reflects every accepted write.
- R10: An accepted write is visible on reads and outputs from the clock edge that samples it. The error strobe goes high for exactly the cycle after that edge when any part of the write was dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe |
| csr_space | input | 2 | Register space: 0 config words, 1 address, 2 security, 3 reserved |
| csr_idx | input | IDX_W | Word or entry index within the space |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for space/index |
| wr_err | output | 1 | One-cycle strobe: part of the last write was dropped |
| entry_cfg | output | N*8 | All configuration bytes, entry e at bits 8e+7:8e |
| entry_addr | output | N*XLEN | All address registers, entry e at lane e |
| entry_lock | output | N | Lock bit of each entry |
| sec_cfg | output | 3 | Security bits {bypass, whitelist, lockdown} |
| active_cnt | output | CNT_W | Number of entries whose mode is not off |

## Verification
A write is driven on a falling edge and stored at the next rising edge, so the error strobe, the stored registers, the lock vector and the active count are all due one cycle after the strobe. The bench samples all of them at the falling edge that follows that rising edge. Read data is combinational, so the bench applies a read index at a falling edge and samples one nanosecond later. It also confirms that the error strobe has dropped again one cycle after a refused write. Expected values come from a model in the bench that applies each rule to the state as it stood before the write.

// File: rtl/pmpb_pkg.sv
package pmpb_pkg;

    typedef enum logic [1:0] {
        AM_OFF   = 2'd0,
        AM_TOR   = 2'd1,
        AM_NA4   = 2'd2,
        AM_NAPOT = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        SP_CFG  = 2'd0,
        SP_ADDR = 2'd1,
        SP_SEC  = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    // Entry configuration byte, msb first: lock, reserved, mode, x, w, r
    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        amode_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } cfg_byte_t;

    // Security bits, msb first: bypass, whitelist, lockdown
    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } sec_t;

    localparam logic [2:0] RWX_SHARED = 3'b110;

    function automatic logic cfg_write_ok(
        input logic      enh,
        input logic      bypass,
        input logic      lockdown,
        input logic      cur_lock,
        input cfg_byte_t nv
    );
        logic ok;
        ok = !cur_lock;
        if (enh) begin
            ok = 1'b0;
            if (bypass)
                ok = 1'b1;
            if (!lockdown && !cur_lock)
                ok = 1'b1;
            if (lockdown) begin
                if (nv.lock && !nv.x)
                    ok = 1'b1;
                if (!nv.lock && ({nv.x, nv.w, nv.r} != RWX_SHARED))
                    ok = 1'b1;
            end
        end
        return ok;
    endfunction

    function automatic logic addr_write_ok(
        input logic cur_lock,
        input logic next_tor_locked
    );
        return !cur_lock && !next_tor_locked;
    endfunction

endpackage

// File: rtl/pmpb_entry.sv
module pmpb_entry
    import pmpb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter bit ENHANCED = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  cfg_byte_t       cfg_wval,
    input  logic            addr_we,
    input  logic [XLEN-1:0] addr_wval,
    input  logic            next_tor_locked,
    input  logic            bypass,
    input  logic            lockdown,
    output cfg_byte_t       cfg_q,
    output logic [XLEN-1:0] addr_q,
    output logic            cfg_drop,
    output logic            addr_drop
);

    logic cfg_ok;
    logic addr_ok;

    assign cfg_ok    = cfg_write_ok(ENHANCED, bypass, lockdown, cfg_q.lock, cfg_wval);
    assign addr_ok   = addr_write_ok(cfg_q.lock, next_tor_locked);
    assign cfg_drop  = cfg_we && !cfg_ok;
    assign addr_drop = addr_we && !addr_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cfg_we && cfg_ok)
                cfg_q <= cfg_wval;
            if (addr_we && addr_ok)
                addr_q <= addr_wval;
        end
    end

endmodule

// File: rtl/pmpb_sec_reg.sv
module pmpb_sec_reg
    import pmpb_pkg::*;
#(
    parameter bit ENHANCED = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  sec_t wval,
    input  logic any_locked,
    output sec_t sec_q
);

    generate
        if (ENHANCED) begin : g_enh
            sec_t nxt;
            always_comb begin
                nxt = wval;
                if (!sec_q.bypass && any_locked)
                    nxt.bypass = 1'b0;
                nxt.lockdown  = nxt.lockdown  | sec_q.lockdown;
                nxt.whitelist = nxt.whitelist | sec_q.whitelist;
            end
            always_ff @(posedge clk) begin
                if (rst)
                    sec_q <= '0;
                else if (we)
                    sec_q <= nxt;
            end
        end else begin : g_base
            logic unused_ok;
            assign unused_ok = ^{clk, rst, we, wval, any_locked};
            assign sec_q     = '0;
        end
    endgenerate

endmodule

// File: rtl/pmpb_active_count.sv
module pmpb_active_count #(
    parameter int N     = 16,
    parameter int CNT_W = $clog2(N + 1)
) (
    input  logic [2*N-1:0]   mode_flat,
    output logic [CNT_W-1:0] cnt
);

    always_comb begin
        cnt = '0;
        for (int e = 0; e < N; e++) begin
            if (mode_flat[2*e +: 2] != 2'b00)
                cnt = cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
    import pmpb_pkg::*;
#(
    parameter int N        = 16,
    parameter int XLEN     = 32,
    parameter int IDX_W    = 6,
    parameter bit ENHANCED = 1'b1,
    localparam int BPW     = XLEN / 8,
    localparam int NCW     = (N + BPW - 1) / BPW,
    localparam int CNT_W   = $clog2(N + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_we,
    input  logic [1:0]        csr_space,
    input  logic [IDX_W-1:0]  csr_idx,
    input  logic [XLEN-1:0]   csr_wdata,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              wr_err,
    output logic [N*8-1:0]    entry_cfg,
    output logic [N*XLEN-1:0] entry_addr,
    output logic [N-1:0]      entry_lock,
    output logic [2:0]        sec_cfg,
    output logic [CNT_W-1:0]  active_cnt
);

    space_e    space;
    cfg_byte_t cfg_q    [N];
    logic [XLEN-1:0] addr_q [N];
    logic [N-1:0] cfg_we;
    logic [N-1:0] addr_we;
    logic [N-1:0] cfg_drop;
    logic [N-1:0] addr_drop;
    logic [N-1:0] next_tor_locked;
    logic [2*N-1:0] mode_flat;
    logic       cfg_hit;
    logic       oor_write;
    logic       any_drop;
    logic       err_q;
    sec_t       sec_q;

    assign space   = space_e'(csr_space);
    assign cfg_hit = csr_we && (space == SP_CFG) && (csr_idx < IDX_W'(NCW));

    assign oor_write = csr_we && (
        ((space == SP_CFG)  && (csr_idx >= IDX_W'(NCW))) ||
        ((space == SP_ADDR) && (csr_idx >= IDX_W'(N)))   ||
        (space == SP_RSVD));

    generate
        for (genvar e = 0; e < N; e++) begin : g_entry
            localparam int WORD = e / BPW;
            localparam int LANE = e % BPW;

            assign cfg_we[e]  = cfg_hit && (csr_idx == IDX_W'(WORD));
            assign addr_we[e] = csr_we && (space == SP_ADDR) && (csr_idx == IDX_W'(e));

            if (e + 1 < N) begin : g_succ
                assign next_tor_locked[e] = cfg_q[e+1].lock && (cfg_q[e+1].mode == AM_TOR);
            end else begin : g_last
                assign next_tor_locked[e] = 1'b0;
            end

            pmpb_entry #(
                .XLEN     (XLEN),
                .ENHANCED (ENHANCED)
            ) u_entry (
                .clk             (clk),
                .rst             (rst),
                .cfg_we          (cfg_we[e]),
                .cfg_wval        (cfg_byte_t'(csr_wdata[LANE*8 +: 8])),
                .addr_we         (addr_we[e]),
                .addr_wval       (csr_wdata),
                .next_tor_locked (next_tor_locked[e]),
                .bypass          (sec_q.bypass),
                .lockdown        (sec_q.lockdown),
                .cfg_q           (cfg_q[e]),
                .addr_q          (addr_q[e]),
                .cfg_drop        (cfg_drop[e]),
                .addr_drop       (addr_drop[e])
            );

            assign entry_cfg[e*8 +: 8]        = cfg_q[e];
            assign entry_addr[e*XLEN +: XLEN] = addr_q[e];
            assign entry_lock[e]              = cfg_q[e].lock;
            assign mode_flat[2*e +: 2]        = cfg_q[e].mode;
        end
    endgenerate

    pmpb_sec_reg #(
        .ENHANCED (ENHANCED)
    ) u_sec (
        .clk        (clk),
        .rst        (rst),
        .we         (csr_we && (space == SP_SEC)),
        .wval       (sec_t'(csr_wdata[2:0])),
        .any_locked (|entry_lock),
        .sec_q      (sec_q)
    );

    pmpb_active_count #(
        .N     (N),
        .CNT_W (CNT_W)
    ) u_count (
        .mode_flat (mode_flat),
        .cnt       (active_cnt)
    );

    assign any_drop = (|cfg_drop) || (|addr_drop) || oor_write;

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= any_drop;
    end

    always_comb begin
        csr_rdata = '0;
        case (space)
            SP_CFG: begin
                for (int e = 0; e < N; e++) begin
                    if (csr_idx == IDX_W'(e / BPW))
                        csr_rdata[(e % BPW)*8 +: 8] = cfg_q[e];
                end
            end
            SP_ADDR: begin
                for (int e = 0; e < N; e++) begin
                    if (csr_idx == IDX_W'(e))
                        csr_rdata = addr_q[e];
                end
            end
            SP_SEC:  csr_rdata = XLEN'(sec_q);
            default: csr_rdata = '0;
        endcase
    end

    assign wr_err  = err_q;
    assign sec_cfg = sec_q;

endmodule

// File: rtl/pmp_csr_bank_chk.sv
module pmp_csr_bank_chk #(
    parameter int N     = 16,
    parameter int XLEN  = 32,
    parameter int IDX_W = 6,
    parameter int CNT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_we,
    input logic [1:0]        csr_space,
    input logic [IDX_W-1:0]  csr_idx,
    input logic              wr_err,
    input logic [N*8-1:0]    entry_cfg,
    input logic [N*XLEN-1:0] entry_addr,
    input logic [N-1:0]      entry_lock,
    input logic [2:0]        sec_cfg,
    input logic [CNT_W-1:0]  active_cnt
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (sec_cfg == 3'b000) && (entry_cfg == '0) && (active_cnt == '0) && !wr_err);

    // R10
    err_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> !wr_err);

    // R10
    idle_cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> $stable(entry_cfg) && $stable(entry_addr) && $stable(sec_cfg));

    // R9
    idle_count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> $stable(active_cnt));

    // R8
    lockdown_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sec_cfg[0] |=> sec_cfg[0]);

    // R8
    whitelist_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        sec_cfg[1] |=> sec_cfg[1]);

    // R8
    bypass_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (!sec_cfg[2] && (|entry_lock)) |=> !sec_cfg[2]);

    generate
        for (genvar e = 0; e < N; e++) begin : g_addr
            // R6
            addr_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (csr_we && (csr_space == 2'd1) && (csr_idx == IDX_W'(e)) && entry_lock[e])
                |=> $stable(entry_addr[e*XLEN +: XLEN]));
        end
    endgenerate

endmodule

bind pmp_csr_bank pmp_csr_bank_chk #(
    .N     (N),
    .XLEN  (XLEN),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .csr_we     (csr_we),
    .csr_space  (csr_space),
    .csr_idx    (csr_idx),
    .wr_err     (wr_err),
    .entry_cfg  (entry_cfg),
    .entry_addr (entry_addr),
    .entry_lock (entry_lock),
    .sec_cfg    (sec_cfg),
    .active_cnt (active_cnt)
);

// File: tb/pmp_csr_bank_tb.sv
`timescale 1ns/1ps
module pmp_csr_bank_tb;

    localparam int N     = 16;
    localparam int XLEN  = 32;
    localparam int IDX_W = 6;
    localparam int BPW   = XLEN / 8;
    localparam int NCW   = (N + BPW - 1) / BPW;
    localparam int CNT_W = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              csr_we = 1'b0;
    logic [1:0]        csr_space = 2'd0;
    logic [IDX_W-1:0]  csr_idx = '0;
    logic [XLEN-1:0]   csr_wdata = '0;
    logic [XLEN-1:0]   csr_rdata;
    logic              wr_err;
    logic [N*8-1:0]    entry_cfg;
    logic [N*XLEN-1:0] entry_addr;
    logic [N-1:0]      entry_lock;
    logic [2:0]        sec_cfg;
    logic [CNT_W-1:0]  active_cnt;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [7:0]      m_cfg  [N];
    logic [XLEN-1:0] m_addr [N];
    logic [2:0]      m_sec;

    always #2 clk = ~clk;

    pmp_csr_bank #(.N(N), .XLEN(XLEN), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_space(csr_space),
        .csr_idx(csr_idx), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .wr_err(wr_err), .entry_cfg(entry_cfg), .entry_addr(entry_addr),
        .entry_lock(entry_lock), .sec_cfg(sec_cfg), .active_cnt(active_cnt)
    );

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL R10 watchdog expired: actual %0d cycles expected fewer", cycles);
            summary();
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic bit m_any_lock();
        for (int e = 0; e < N; e++)
            if (m_cfg[e][7]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_cfg_ok(input int e, input logic [7:0] v);
        if (m_sec[2]) return 1'b1;
        if (!m_sec[0] && !m_cfg[e][7]) return 1'b1;
        if (m_sec[0]) begin
            if (v[7] && !v[2]) return 1'b1;
            if (!v[7] && v[2:0] != 3'b110) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit m_addr_ok(input int e);
        if (m_cfg[e][7]) return 1'b0;
        if (e + 1 < N && m_cfg[e+1][7] && m_cfg[e+1][4:3] == 2'b01) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [XLEN-1:0] m_read(input logic [1:0] sp, input int idx);
        logic [XLEN-1:0] r = '0;
        if (sp == 2'd0 && idx < NCW) begin
            for (int l = 0; l < BPW; l++)
                if (idx * BPW + l < N) r[l*8 +: 8] = m_cfg[idx*BPW + l];
        end else if (sp == 2'd1 && idx < N) begin
            r = m_addr[idx];
        end else if (sp == 2'd2) begin
            r = XLEN'(m_sec);
        end
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] m_count();
        logic [CNT_W-1:0] c = '0;
        for (int e = 0; e < N; e++)
            if (m_cfg[e][4:3] != 2'b00) c = c + CNT_W'(1);
        return c;
    endfunction

    function automatic logic [N-1:0] m_locks();
        logic [N-1:0] v;
        for (int e = 0; e < N; e++) v[e] = m_cfg[e][7];
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        csr_we = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int e = 0; e < N; e++) begin
            m_cfg[e]  = '0;
            m_addr[e] = '0;
        end
        m_sec = '0;
    endtask

    task automatic rd_chk(input logic [1:0] sp, input int idx, input string tag);
        @(negedge clk);
        csr_space = sp;
        csr_idx   = IDX_W'(idx);
        #1;
        chk(csr_rdata == m_read(sp, idx), tag, csr_rdata, m_read(sp, idx));
    endtask

    task automatic wr(input logic [1:0] sp, input int idx, input logic [XLEN-1:0] d,
                      input string tag);
        bit              exp_err = 1'b0;
        logic [7:0]      n_cfg  [N];
        logic [XLEN-1:0] n_addr [N];
        logic [2:0]      n_sec = m_sec;
        for (int e = 0; e < N; e++) begin
            n_cfg[e]  = m_cfg[e];
            n_addr[e] = m_addr[e];
        end
        case (sp)
            2'd0: if (idx < NCW) begin
                for (int l = 0; l < BPW; l++) begin
                    int e = idx * BPW + l;
                    if (e < N) begin
                        if (m_cfg_ok(e, d[l*8 +: 8])) n_cfg[e] = d[l*8 +: 8];
                        else exp_err = 1'b1;
                    end
                end
            end else exp_err = 1'b1;
            2'd1: if (idx < N) begin
                if (m_addr_ok(idx)) n_addr[idx] = d;
                else exp_err = 1'b1;
            end else exp_err = 1'b1;
            2'd2: begin
                n_sec = d[2:0];
                if (!m_sec[2] && m_any_lock()) n_sec[2] = 1'b0;
                n_sec[0] = n_sec[0] | m_sec[0];
                n_sec[1] = n_sec[1] | m_sec[1];
            end
            default: exp_err = 1'b1;
        endcase
        @(negedge clk);
        csr_we    = 1'b1;
        csr_space = sp;
        csr_idx   = IDX_W'(idx);
        csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
        chk(wr_err == exp_err, {tag, " R10 error strobe"}, XLEN'(wr_err), XLEN'(exp_err));
        for (int e = 0; e < N; e++) begin
            m_cfg[e]  = n_cfg[e];
            m_addr[e] = n_addr[e];
        end
        m_sec = n_sec;
        chk(active_cnt == m_count(), {tag, " R9 active count"}, XLEN'(active_cnt), XLEN'(m_count()));
        chk(entry_lock == m_locks(), {tag, " R2 lock vector"}, XLEN'(entry_lock), XLEN'(m_locks()));
        chk(sec_cfg == m_sec, {tag, " R8 security bits"}, XLEN'(sec_cfg), XLEN'(m_sec));
        rd_chk(sp, idx, {tag, " readback"});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk(wr_err == 1'b0, "R1 err low", XLEN'(wr_err), '0);
        chk(active_cnt == '0, "R1 count zero", XLEN'(active_cnt), '0);
        chk(entry_cfg == '0 && entry_addr == '0, "R1 entries zero", XLEN'(entry_cfg[31:0]), '0);
        rd_chk(2'd0, 0, "R1 cfg word");
        rd_chk(2'd1, 5, "R1 addr reg");
        rd_chk(2'd2, 0, "R1 security");

        // R2 packing, R9 count
        wr(2'd0, 0, 32'h97_00_1B_08, "R2 word0 lanes");
        chk(entry_cfg[3*8 +: 8] == 8'h97, "R2 lane3 to entry3", XLEN'(entry_cfg[3*8 +: 8]), 32'h97);
        chk(active_cnt == CNT_W'(3), "R9 three active", XLEN'(active_cnt), 32'd3);
        wr(2'd0, 3, 32'h00_00_10_00, "R2 word3 entry13");
        chk(entry_cfg[13*8 +: 8] == 8'h10, "R2 lane1 word3", XLEN'(entry_cfg[13*8 +: 8]), 32'h10);

        // R6 own lock, non-TOR neighbour
        wr(2'd1, 3, 32'hDEAD_0000, "R6 own lock drops");
        wr(2'd1, 2, 32'h1234_5678, "R6 NA4 neighbour allows");
        // R3 partial word
        wr(2'd0, 0, 32'h00_11_11_11, "R3 locked lane dropped");
        chk(entry_cfg[3*8 +: 8] == 8'h97, "R3 entry3 kept", XLEN'(entry_cfg[3*8 +: 8]), 32'h97);
        chk(entry_cfg[0 +: 8] == 8'h11, "R3 entry0 written", XLEN'(entry_cfg[0 +: 8]), 32'h11);
        // R6 TOR successor lock
        wr(2'd0, 1, 32'h00_00_88_00, "R6 lock entry5 TOR");
        wr(2'd1, 4, 32'hAAAA_5555, "R6 TOR successor drops");
        wr(2'd1, 15, 32'h0F0F_F0F0, "R6 last entry");
        // R10 strobe lasts one cycle
        wr(2'd1, 4, 32'h1, "R10 drop again");
        @(negedge clk);
        chk(wr_err == 1'b0, "R10 strobe one cycle", XLEN'(wr_err), '0);

        // R8 security register
        wr(2'd2, 0, 32'h4, "R8 bypass blocked");
        chk(sec_cfg[2] == 1'b0, "R8 bypass stays 0", XLEN'(sec_cfg), '0);
        wr(2'd2, 0, 32'h3, "R8 set lockdown whitelist");
        wr(2'd2, 0, 32'h0, "R8 sticky bits");
        chk(sec_cfg == 3'b011, "R8 sticky kept", XLEN'(sec_cfg), 32'h3);

        // R5 lockdown rules
        wr(2'd0, 0, 32'h83_00_06_05, "R5 mixed lanes");
        chk(entry_cfg[3*8 +: 8] == 8'h83, "R5 locked RW accepted", XLEN'(entry_cfg[3*8 +: 8]), 32'h83);
        chk(entry_cfg[1*8 +: 8] == 8'h11, "R5 shared WX dropped", XLEN'(entry_cfg[1*8 +: 8]), 32'h11);
        wr(2'd0, 0, 32'h84_00_11_05, "R5 locked X dropped");

        // R7 out of range
        wr(2'd0, NCW, 32'hFFFF_FFFF, "R7 cfg word oor");
        wr(2'd1, N, 32'hFFFF_FFFF, "R7 addr oor");
        wr(2'd3, 0, 32'hFFFF_FFFF, "R7 reserved space");
        rd_chk(2'd3, 1, "R7 reserved read");
        rd_chk(2'd1, N + 1, "R7 addr read oor");

        // R4 bypass
        do_reset();
        wr(2'd2, 0, 32'h4, "R4 bypass set");
        wr(2'd0, 0, 32'h80_80_80_80, "R4 lock all");
        wr(2'd2, 0, 32'h5, "R4 lockdown on");
        wr(2'd0, 0, 32'h06_8C_07_18, "R4 locked rewritten");
        chk(entry_cfg[31:0] == 32'h068C0718, "R4 all lanes", entry_cfg[31:0], 32'h068C0718);

        // R3 plain mode randomised, R5 R8 with random sec writes
        do_reset();
        for (int n = 0; n < 700; n++) begin
            int          r   = $urandom % 12;
            logic [31:0] d   = $urandom;
            if (n % 175 == 174) do_reset();
            if (r < 6) begin
                if ($urandom % 3 != 0) d = d & 32'h7F7F7F7F;
                wr(2'd0, $urandom % (NCW + 1), d, "R3 R5 random cfg");
            end else if (r < 9) begin
                wr(2'd1, $urandom % (N + 2), d, "R6 random addr");
            end else if (r < 11) begin
                if ($urandom % 4 != 0) d = d & 32'h4;
                wr(2'd2, 0, d, "R8 random sec");
            end else begin
                wr(2'd3, $urandom % 4, d, "R7 random reserved");
            end
        end
        for (int k = 0; k < NCW; k++) rd_chk(2'd0, k, "R2 final cfg sweep");
        summary();
    end

endmodule